// File: doc/BRIEF.md
# Justification Elastic Buffer Controller

This block is the elastic store between the tributary write side, which delivers the 139.264 Mbit/s stream a byte at a time, and the container build side, which takes bytes at its information-bit opportunities. The model runs on one clock. Each side has its own enable strobe, so the two sides' average rates may differ. The block keeps a fill count. At the first justification-control slot of each subframe it decides whether that subframe's stuff-opportunity bit will carry data or a stuffing bit. It then presents the decision as five identical control bits. A frame holds nine subframes, and each subframe gets one such decision.

An overflow or an underflow raises an error alarm. The block then recenters its pointers so that the buffer is half full, and it freezes for one frame's worth of byte clocks (by default 2430) before it accepts traffic again. Reset performs the same recenter and the same freeze, but it does not raise the alarm.

Top module: `justif_fifo`

## Requirements
- R1: While reset is asserted and right after it, `fill` reads DEPTH/2, `holding` is 1, and `fifo_err`, `stuff` and `c_bits` are all 0.
- R2: After reset or after an error, `holding` stays 1 for exactly HOLD_CYC rising clock edges and then falls. While it is 1, `wr_en` and `rd_en` have no effect, and `fill` stays at DEPTH/2.
- R3: Bytes come out in the order they were written. `rd_data` shows the byte for a read one cycle after the `rd_en` that took it.
- R4: Outside the hold, a lone write raises `fill` by 1, a lone read lowers it by 1, and a write together with a read leaves it unchanged. `fill` never exceeds DEPTH.
- R5: A write without a read while `fill` equals DEPTH is an overflow. On the next cycle `fifo_err` is 1, `holding` is 1 and `fill` is DEPTH/2.
- R6: A read while `fill` is 0 is an underflow, whether or not a write comes with it. On the next cycle `fifo_err` is 1, `holding` is 1 and `fill` is DEPTH/2.
- R7: `fifo_err` stays 1 for the whole hold that follows an error. It falls on the same edge as `holding`.
- R8: On a `c_slot` pulse, a fill below LOW_TH sets `stuff` to 1 and `c_bits` to 5'b11111, meaning the S-bit carries stuffing. Any other fill sets `stuff` to 0 and `c_bits` to 5'b00000, meaning the S-bit carries data.
- R9: The decision changes only on the edge that samples `c_slot`. Fill changes between pulses leave `stuff` and `c_bits` unchanged.
- R10: A write together with a read while `fill` equals DEPTH is accepted without error, and `fill` stays at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low reset, recenters and starts the hold |
| wr_en | input | 1 | Write strobe from the tributary side |
| wr_data | input | W | Byte to store |
| rd_en | input | 1 | Read strobe at a container information opportunity |
| c_slot | input | 1 | Pulse at the first control-bit slot of a subframe |
| rd_data | output | W | Byte taken by the last accepted read |
| c_bits | output | 5 | Control-bit pattern for the current subframe |
| stuff | output | 1 | 1 when the S-bit carries stuffing |
| fifo_err | output | 1 | Overflow or underflow alarm, high during the recovery hold |
| holding | output | 1 | Buffer frozen after reset or an error |
| fill | output | AW+1 | Current fill level in bytes |

## Verification
A wrong fill count shows at the ports within one cycle, because `fill` is a port. It also shows at the next `c_slot`, as a stuff decision that goes the wrong way. A read pointer that has slipped gives out-of-order `rd_data` on the first read after the slip. A hold counter loaded with the wrong value only becomes visible when `holding` falls. The bench therefore counts the hold edge by edge after reset and after an error. It also drains the buffer to empty and fills it to full, to reach both error edges.

// File: rtl/justif_fifo.sv
module justif_fifo #(
  parameter int W        = 8,
  parameter int DEPTH    = 16,
  parameter int LOW_TH   = 6,
  parameter int HOLD_CYC = 2430
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [W-1:0]   wr_data,
  input  logic           rd_en,
  input  logic           c_slot,
  output logic [W-1:0]   rd_data,
  output logic [4:0]     c_bits,
  output logic           stuff,
  output logic           fifo_err,
  output logic           holding,
  output logic [$clog2(DEPTH):0] fill
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [AW:0]   FULL_LVL = (AW+1)'(DEPTH);
  localparam logic [AW:0]   HALF_LVL = (AW+1)'(DEPTH/2);
  localparam logic [AW:0]   LOW_LVL  = (AW+1)'(LOW_TH);
  localparam logic [AW-1:0] HALF_PTR = AW'(DEPTH/2);
  localparam logic [CW-1:0] HOLD_LD  = CW'(HOLD_CYC-1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] hold_cnt;
  logic          stuff_q, err_q;

  wire ovf   = !holding && wr_en && !rd_en && (fill == FULL_LVL);
  wire udf   = !holding && rd_en && (fill == '0);
  wire err   = ovf || udf;
  wire wr_go = !holding && !err && wr_en;
  wire rd_go = !holding && !err && rd_en;

  assign stuff    = stuff_q;
  assign c_bits   = {5{stuff_q}};
  assign fifo_err = err_q;

  always_ff @(posedge clk)
    if (wr_go) mem[wptr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= HALF_PTR;
      rptr     <= '0;
      fill     <= HALF_LVL;
      holding  <= 1'b1;
      hold_cnt <= HOLD_LD;
      err_q    <= 1'b0;
      stuff_q  <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (err) begin
        rptr     <= wptr - HALF_PTR;
        fill     <= HALF_LVL;
        holding  <= 1'b1;
        hold_cnt <= HOLD_LD;
        err_q    <= 1'b1;
      end else if (holding) begin
        if (hold_cnt == '0) begin
          holding <= 1'b0;
          err_q   <= 1'b0;
        end else begin
          hold_cnt <= hold_cnt - 1'b1;
        end
      end else begin
        if (wr_go) wptr <= wptr + 1'b1;
        if (rd_go) begin
          rptr    <= rptr + 1'b1;
          rd_data <= mem[rptr];
        end
        fill <= fill + (AW+1)'(wr_go) - (AW+1)'(rd_go);
      end
      if (c_slot) stuff_q <= (fill < LOW_LVL);
    end
  end

  assert_fill_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL_LVL);
  assert_hold_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    holding |=> (!holding || fill == HALF_LVL));
  assert_err_in_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_err |-> holding);
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!holding && wr_en && !rd_en && fill == FULL_LVL) |=> (fifo_err && holding && fill == HALF_LVL));
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!holding && rd_en && fill == '0) |=> (fifo_err && holding && fill == HALF_LVL));
  assert_decision_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !c_slot |=> $stable(c_bits));
  assert_full_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!holding && wr_en && rd_en && fill == FULL_LVL) |=> (!fifo_err && fill == FULL_LVL));
endmodule

// File: tb/tb_justif_fifo.sv
module tb_justif_fifo;
  localparam int DEPTH = 16;
  localparam int HOLD  = 30;
  localparam int LOWT  = 6;
  localparam int NV    = 12;

  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, rd_en = 0, c_slot = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic [4:0] c_bits;
  logic       stuff, fifo_err, holding;
  logic [4:0] fill;
  int checks = 0, errors = 0;

  justif_fifo #(.W(8), .DEPTH(DEPTH), .LOW_TH(LOWT), .HOLD_CYC(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .c_slot(c_slot), .rd_data(rd_data), .c_bits(c_bits), .stuff(stuff),
    .fifo_err(fifo_err), .holding(holding), .fill(fill));

  always #10 clk = ~clk;

  // {wr, rd, c_slot, expected stuff, unused, expected fill}
  localparam logic [9:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,1'b0,1'b0,5'd9},
    {1'b1,1'b1,1'b0,1'b0,1'b0,5'd9},
    {1'b0,1'b1,1'b0,1'b0,1'b0,5'd8},
    {1'b0,1'b1,1'b0,1'b0,1'b0,5'd7},
    {1'b0,1'b1,1'b0,1'b0,1'b0,5'd6},
    {1'b0,1'b0,1'b1,1'b0,1'b0,5'd6},
    {1'b0,1'b1,1'b0,1'b0,1'b0,5'd5},
    {1'b0,1'b0,1'b1,1'b1,1'b0,5'd5},
    {1'b1,1'b0,1'b0,1'b1,1'b0,5'd6},
    {1'b1,1'b0,1'b0,1'b1,1'b0,5'd7},
    {1'b0,1'b0,1'b1,1'b0,1'b0,5'd7},
    {1'b0,1'b0,1'b0,1'b0,1'b0,5'd7}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit w, input bit r, input bit c, input logic [7:0] d);
    wr_en = w; rd_en = r; c_slot = c; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0; rd_en = 0; c_slot = 0;
  endtask

  task automatic ride_hold(input bit exp_err, input string tag);
    for (int i = 0; i < HOLD; i++) begin
      chk(holding == 1'b1, tag, holding, 1);
      chk(fifo_err == exp_err, "R7 err during hold", fifo_err, exp_err);
      cyc(1'b1, 1'b1, 1'b0, 8'hEE);
      chk(fill == 5'd8, "R2 fill frozen", fill, 8);
    end
    chk(holding == 1'b0, tag, holding, 0);
    chk(fifo_err == 1'b0, "R7 err clears with hold", fifo_err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(fill == 5'd8, "R1 fill at reset", fill, 8);
    chk(holding == 1'b1, "R1 holding at reset", holding, 1);
    chk(fifo_err == 1'b0, "R1 err at reset", fifo_err, 0);
    chk(stuff == 1'b0 && c_bits == 5'd0, "R1 decision at reset", c_bits, 0);
    rst_n = 1;
    ride_hold(1'b0, "R2 hold after reset");

    for (int v = 0; v < NV; v++) begin
      cyc(VEC[v][9], VEC[v][8], VEC[v][7], 8'(v));
      chk(fill == VEC[v][4:0], "R4 fill vector", fill, VEC[v][4:0]);
      chk(stuff == VEC[v][6], VEC[v][7] ? "R8 stuff decision" : "R9 decision held",
          stuff, VEC[v][6]);
      chk(c_bits == {5{VEC[v][6]}}, "R8 c_bits pattern", c_bits, {5{VEC[v][6]}});
    end

    for (int i = 0; i < 7; i++) cyc(1'b0, 1'b1, 1'b0, 8'h00);
    chk(fill == 5'd0, "R4 drained", fill, 0);
    cyc(1'b0, 1'b0, 1'b1, 8'h00);
    chk(c_bits == 5'b11111, "R8 stuff at empty", c_bits, 31);
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 1'b0, 8'hA0 + 8'(i));
    chk(fill == 5'd5, "R4 refill", fill, 5);
    for (int i = 0; i < 5; i++) begin
      cyc(1'b0, 1'b1, 1'b0, 8'h00);
      chk(rd_data == 8'hA0 + 8'(i), "R3 read order", rd_data, 8'hA0 + i);
    end
    cyc(1'b1, 1'b1, 1'b0, 8'h55);
    chk(fifo_err == 1'b1 && holding == 1'b1, "R6 underflow alarm", fifo_err, 1);
    chk(fill == 5'd8, "R6 recenter", fill, 8);
    ride_hold(1'b1, "R2 hold after underflow");

    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, 1'b0, 8'hC0 + 8'(i));
    chk(fill == 5'd16, "R4 full", fill, 16);
    cyc(1'b1, 1'b1, 1'b0, 8'h77);
    chk(fill == 5'd16 && fifo_err == 1'b0, "R10 full write and read", fill, 16);
    cyc(1'b1, 1'b0, 1'b0, 8'h99);
    chk(fifo_err == 1'b1 && holding == 1'b1, "R5 overflow alarm", fifo_err, 1);
    chk(fill == 5'd8, "R5 recenter", fill, 8);
    ride_hold(1'b1, "R2 hold after overflow");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule